// File: doc/BRIEF.md
# Two-Port CPU Bus Slave with Ready Stalling

This block sits on an 8-bit 65xx-style processor bus. It shows the CPU only two addressable locations, chosen by a single register-select input. One location is a data port into a large video memory. The other is a register port. The video memory is reached through an internal auto-incrementing address pointer. That pointer, and the backend's register file, are loaded through two-byte write pairs on the register port.

Every selected access stalls the processor at once by pulling the ready line low. The block then hands the access to an internal backend over a level request / pulse acknowledge handshake. When the backend answers, the block captures read data, releases ready and drives the data bus until the CPU deselects the block. If the backend stays silent too long, a timeout counter forces the release. A diagnostic mode bypasses the backend completely. In that mode both ports behave as one self-incrementing byte.

All bus inputs are sampled on the block's own clock. An optional synchronizer depth can be set for buses that are asynchronous to that clock.

Top module: `vbs_bus_slave`

## Requirements
- R1: An access is decoded from the register select and the read/write line as sampled at its start: select 0 is the video-memory data port, select 1 is the register port, and a read/write line of 1 means read.
- R2: An access starts only on a clock edge where the strobe is high and chip-select is low; chip-select low while the strobe is low, or the strobe high while chip-select is high, starts nothing, so ready stays high and no backend request is raised.
- R3: Ready falls on the edge that starts an access and stays low for at least one cycle and, for a backend access, until the acknowledge arrives.
- R4: A data-port read or write raises a backend request with `be_is_reg`=0 and `be_addr` equal to the pointer. After each completed data-port access the pointer advances by one, wrapping from 0x7FFF to 0x0000.
- R5: A register-port write is the first or second byte of a pair, and the first byte is held. If bit 7 of the second byte is 1, the block issues a backend register write: the index is bits 2:0 of the second byte and the data is the held byte. If bit 7 is 0, the pointer is loaded with {second byte bits 6:0, held byte} and no backend request is made.
- R6: A register-port read issues a backend register read of index 0 and returns its data. It also resets the pair sequencing, so the next register-port write is taken as a first byte.
- R7: A backend request holds its address and data steady until acknowledged. If no acknowledge arrives within 16 cycles (TIMEOUT), ready is released anyway. A read that times out returns 0xFF and leaves the pointer unchanged.
- R8: The data output enable is 0 throughout a stall and for writes. After a read completes it is 1 together with the read byte. It returns to 0 one cycle after chip-select goes high.
- R9: With `diag_en`=1, a read of either port returns a diagnostic byte, which then advances by one. A write to either port loads that byte. No backend request is raised.
- R10: After reset, ready is 1, the output enable is 0, no request is raised, the pointer is 0x0000 and the next register write is taken as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_en | input | 1 | Diagnostic byte mode |
| bus_phi2 | input | 1 | CPU bus strobe, high in the data phase |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rs | input | 1 | Register select: 0 data port, 1 register port |
| bus_rwb | input | 1 | 1 read, 0 write |
| bus_din | input | 8 | Write data from the CPU |
| bus_dout | output | 8 | Read data to the CPU |
| bus_doe | output | 1 | Data bus output enable |
| bus_rdy | output | 1 | Ready, low stalls the CPU |
| be_req | output | 1 | Backend request, held until acknowledge |
| be_wr | output | 1 | Backend access is a write |
| be_is_reg | output | 1 | Backend access targets the register file |
| be_addr | output | 15 | Memory address or register index |
| be_wdata | output | 8 | Backend write data |
| be_ack | input | 1 | Backend acknowledge, one-cycle pulse |
| be_rdata | input | 8 | Backend read data, valid with acknowledge |

## Verification
The backend model answers with delays of zero, one and four cycles, and also not at all. Together these show that the length of the stall follows the acknowledge, and that the timeout alone ends a silent access. Register-port pairs are sent with bit 7 set and with bit 7 clear, and one pair is broken by a register read. Reading back through the data port shows whether the pointer, the register file or neither was loaded. Diagnostic traffic, and chip-select patterns with the strobe low, must leave the request count unchanged. This separates true starts from ignored bus activity. Last, a write at 0x7FFF is followed by a read that must go to address 0.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_HOLD = 2'd2
   } state_t;

   typedef enum logic [2:0] {
      OP_MEM_RD       = 3'd0,
      OP_MEM_WR       = 3'd1,
      OP_REG_RD       = 3'd2,
      OP_REG_WR_LO    = 3'd3,
      OP_REG_WR_PTR   = 3'd4,
      OP_REG_WR_REG   = 3'd5,
      OP_DIAG_RD      = 3'd6,
      OP_DIAG_WR      = 3'd7
   } op_t;

   function automatic logic op_needs_backend(op_t op);
      return (op == OP_MEM_RD) || (op == OP_MEM_WR) ||
             (op == OP_REG_RD) || (op == OP_REG_WR_REG);
   endfunction

   function automatic logic op_is_read(op_t op);
      return (op == OP_MEM_RD) || (op == OP_REG_RD) || (op == OP_DIAG_RD);
   endfunction

endpackage

// File: rtl/vbs_sync.sv
module vbs_sync #(
   parameter int          STAGES  = 0,
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("vbs_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_flop
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q = pipe[STAGES-1];
   end

endmodule

// File: rtl/vbs_decode.sv
module vbs_decode
   import vbs_pkg::*;
(
   input  logic diag_en,
   input  logic rs,
   input  logic rwb,
   input  logic d_msb,
   input  logic pair_second,
   output op_t  op
);

   always_comb begin
      if (diag_en)           op = rwb ? OP_DIAG_RD : OP_DIAG_WR;
      else if (!rs)          op = rwb ? OP_MEM_RD  : OP_MEM_WR;
      else if (rwb)          op = OP_REG_RD;
      else if (!pair_second) op = OP_REG_WR_LO;
      else if (d_msb)        op = OP_REG_WR_REG;
      else                   op = OP_REG_WR_PTR;
   end

endmodule

// File: rtl/vbs_regs.sv
module vbs_regs
   import vbs_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              timed_out,
   input  op_t               op_q,
   input  logic [DATA_W-1:0] din_q,
   output logic [ADDR_W-1:0] ptr,
   output logic [DATA_W-1:0] lo_byte,
   output logic              pair_second,
   output logic [DATA_W-1:0] diag_byte
);

   localparam int HI_W = ADDR_W - DATA_W;

   if (HI_W < 1 || HI_W > DATA_W - 1) begin : g_bad_width
      $error("vbs_regs: ADDR_W must leave a pointer high part of 1..DATA_W-1 bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr         <= '0;
         lo_byte     <= '0;
         pair_second <= 1'b0;
         diag_byte   <= '0;
      end else if (done) begin
         unique case (op_q)
            OP_MEM_RD, OP_MEM_WR: if (!timed_out) ptr <= ptr + 1'b1;
            OP_REG_RD:            pair_second <= 1'b0;
            OP_REG_WR_LO: begin
               lo_byte     <= din_q;
               pair_second <= 1'b1;
            end
            OP_REG_WR_PTR: begin
               ptr         <= {din_q[HI_W-1:0], lo_byte};
               pair_second <= 1'b0;
            end
            OP_REG_WR_REG:        pair_second <= 1'b0;
            OP_DIAG_RD:           diag_byte <= diag_byte + 1'b1;
            OP_DIAG_WR:           diag_byte <= din_q;
            default: ;
         endcase
      end
   end

   // R7: a timed-out access must not move the pointer
   assert_ptr_frozen_on_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done && timed_out |=> $stable(ptr));

endmodule

// File: rtl/vbs_fsm.sv
module vbs_fsm
   import vbs_pkg::*;
#(
   parameter int                TIMEOUT = 16,
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] FILL    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              cs_n,
   input  op_t               op_in,
   input  logic [DATA_W-1:0] din,
   input  logic              be_ack,
   input  logic [DATA_W-1:0] be_rdata,
   input  logic [DATA_W-1:0] diag_byte,
   output logic              rdy,
   output logic              doe,
   output logic [DATA_W-1:0] dout,
   output logic              req,
   output op_t               op_q,
   output logic [DATA_W-1:0] din_q,
   output logic              done,
   output logic              timed_out
);

   localparam int TC_W = $clog2(TIMEOUT + 1);
   localparam int LC_W = TC_W + 2;

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("vbs_fsm: TIMEOUT must be at least 2");
   end

   state_t          state;
   logic [TC_W-1:0] tcnt;

   always_comb begin
      done      = 1'b0;
      timed_out = 1'b0;
      if (state == ST_BUSY) begin
         if (!req || be_ack) begin
            done = 1'b1;
         end else if (tcnt == TC_W'(TIMEOUT - 1)) begin
            done      = 1'b1;
            timed_out = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         rdy   <= 1'b1;
         doe   <= 1'b0;
         dout  <= '0;
         req   <= 1'b0;
         op_q  <= OP_MEM_RD;
         din_q <= '0;
         tcnt  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (phi2 && !cs_n) begin
                  state <= ST_BUSY;
                  rdy   <= 1'b0;
                  op_q  <= op_in;
                  din_q <= din;
                  req   <= op_needs_backend(op_in);
                  tcnt  <= '0;
               end
            end
            ST_BUSY: begin
               if (done) begin
                  req   <= 1'b0;
                  rdy   <= 1'b1;
                  doe   <= op_is_read(op_q);
                  state <= ST_HOLD;
                  if (op_is_read(op_q)) begin
                     if (timed_out)                dout <= FILL;
                     else if (op_q == OP_DIAG_RD)  dout <= diag_byte;
                     else                          dout <= be_rdata;
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_HOLD: begin
               if (cs_n) begin
                  doe   <= 1'b0;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Independent stall-length counter for the bound check
   logic [LC_W-1:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_run <= '0;
      else if (rdy)                        low_run <= '0;
      else if (low_run != {LC_W{1'b1}})    low_run <= low_run + 1'b1;
   end

   assert_start_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) && phi2 && !cs_n |=> !rdy);

   assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req && !done |=> req && $stable(op_q) && $stable(din_q));

   assert_stall_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= LC_W'(TIMEOUT + 1));

   assert_oe_quiet_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |-> !doe);

   assert_oe_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      doe && cs_n |=> !doe);

endmodule

// File: rtl/vbs_bus_slave.sv
module vbs_bus_slave
   import vbs_pkg::*;
#(
   parameter int         ADDR_W      = 15,
   parameter int         REG_IDX_W   = 3,
   parameter int         TIMEOUT     = 16,
   parameter logic [7:0] FILL        = 8'hFF,
   parameter int         SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              diag_en,
   input  logic              bus_phi2,
   input  logic              bus_cs_n,
   input  logic              bus_rs,
   input  logic              bus_rwb,
   input  logic [7:0]        bus_din,
   output logic [7:0]        bus_dout,
   output logic              bus_doe,
   output logic              bus_rdy,
   output logic              be_req,
   output logic              be_wr,
   output logic              be_is_reg,
   output logic [ADDR_W-1:0] be_addr,
   output logic [7:0]        be_wdata,
   input  logic              be_ack,
   input  logic [7:0]        be_rdata
);

   localparam int DATA_W = 8;
   localparam int BUS_W  = DATA_W + 4;
   localparam logic [BUS_W-1:0] BUS_RST = {1'b0, 1'b1, 1'b0, 1'b1, {DATA_W{1'b0}}};

   if (REG_IDX_W < 1 || REG_IDX_W > 7) begin : g_bad_idx
      $error("vbs_bus_slave: REG_IDX_W must be 1..7");
   end

   logic [BUS_W-1:0] bus_s;
   logic             phi2_s, cs_n_s, rs_s, rwb_s;
   logic [7:0]       din_s;

   vbs_sync #(.STAGES(SYNC_STAGES), .W(BUS_W), .RST_VAL(BUS_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_phi2, bus_cs_n, bus_rs, bus_rwb, bus_din}),
      .q     (bus_s)
   );
   assign {phi2_s, cs_n_s, rs_s, rwb_s, din_s} = bus_s;

   op_t              op_in, op_q;
   logic             pair_second, done, timed_out;
   logic [7:0]       din_q, lo_byte, diag_byte;
   logic [ADDR_W-1:0] ptr;

   vbs_decode u_decode (
      .diag_en     (diag_en),
      .rs          (rs_s),
      .rwb         (rwb_s),
      .d_msb       (din_s[7]),
      .pair_second (pair_second),
      .op          (op_in)
   );

   vbs_fsm #(.TIMEOUT(TIMEOUT), .DATA_W(DATA_W), .FILL(FILL)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .phi2      (phi2_s),
      .cs_n      (cs_n_s),
      .op_in     (op_in),
      .din       (din_s),
      .be_ack    (be_ack),
      .be_rdata  (be_rdata),
      .diag_byte (diag_byte),
      .rdy       (bus_rdy),
      .doe       (bus_doe),
      .dout      (bus_dout),
      .req       (be_req),
      .op_q      (op_q),
      .din_q     (din_q),
      .done      (done),
      .timed_out (timed_out)
   );

   vbs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (done),
      .timed_out   (timed_out),
      .op_q        (op_q),
      .din_q       (din_q),
      .ptr         (ptr),
      .lo_byte     (lo_byte),
      .pair_second (pair_second),
      .diag_byte   (diag_byte)
   );

   always_comb begin
      be_wr     = (op_q == OP_MEM_WR) || (op_q == OP_REG_WR_REG);
      be_is_reg = (op_q == OP_REG_RD) || (op_q == OP_REG_WR_REG);
      be_wdata  = (op_q == OP_REG_WR_REG) ? lo_byte : din_q;
      if (op_q == OP_REG_WR_REG)  be_addr = {{(ADDR_W-REG_IDX_W){1'b0}}, din_q[REG_IDX_W-1:0]};
      else if (op_q == OP_REG_RD) be_addr = '0;
      else                        be_addr = ptr;
   end

   // R2: no request can appear while idle without a qualified start
   assert_no_spurious_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !be_req && bus_rdy && !(phi2_s && !cs_n_s) |=> !be_req);

endmodule

// File: tb/vbs_bus_slave_tb.sv
module vbs_bus_slave_tb;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        diag_en = 1'b0;
   logic        phi2 = 1'b0, cs_n = 1'b1, rs = 1'b0, rwb = 1'b1;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        doe, rdy;
   logic        be_req, be_wr, be_is_reg, be_ack;
   logic [14:0] be_addr;
   logic [7:0]  be_wdata, be_rdata;

   always #(CLK_P/2) clk = ~clk;

   vbs_bus_slave u_dut (
      .clk (clk), .rst_n (rst_n), .diag_en (diag_en),
      .bus_phi2 (phi2), .bus_cs_n (cs_n), .bus_rs (rs), .bus_rwb (rwb),
      .bus_din (din), .bus_dout (dout), .bus_doe (doe), .bus_rdy (rdy),
      .be_req (be_req), .be_wr (be_wr), .be_is_reg (be_is_reg),
      .be_addr (be_addr), .be_wdata (be_wdata),
      .be_ack (be_ack), .be_rdata (be_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   // ---------------- backend model ----------------
   logic [7:0]  bmem  [256];
   logic [7:0]  bregs [8];
   int          be_dly  = 1;
   logic        be_nack = 1'b0;
   logic        pend = 1'b0, req_prev = 1'b0;
   int          cnt = 0;
   int          req_count = 0;
   logic [14:0] last_addr = '0;
   logic [7:0]  last_wdata = '0;

   initial begin
      for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5A;
      for (int i = 0; i < 8; i++) bregs[i] = '0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         be_ack   <= 1'b0;
         be_rdata <= '0;
         pend     <= 1'b0;
         req_prev <= 1'b0;
      end else begin
         be_ack   <= 1'b0;
         req_prev <= be_req;
         if (be_req && !req_prev) req_count++;
         if (!be_req) pend <= 1'b0;
         else if (!pend && !be_ack) begin
            pend <= 1'b1;
            cnt  <= be_dly;
         end else if (pend && !be_nack) begin
            if (cnt == 0) begin
               be_ack     <= 1'b1;
               pend       <= 1'b0;
               last_addr  <= be_addr;
               last_wdata <= be_wdata;
               if (be_is_reg) begin
                  if (be_wr) bregs[be_addr[2:0]] <= be_wdata;
                  else       be_rdata <= bregs[be_addr[2:0]];
               end else begin
                  if (be_wr) bmem[be_addr[7:0]] <= be_wdata;
                  else       be_rdata <= bmem[be_addr[7:0]];
               end
            end else cnt <= cnt - 1;
         end
      end
   end

   // ---------------- scoreboard ----------------
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       doe_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n && doe && !doe_prev) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R8 unexpected read data: actual 0x%0h expected none", dout);
         end else begin
            chk(tag_q.pop_front(), int'(dout), int'(exp_q.pop_front()));
         end
      end
      doe_prev = doe;
   end

   // ---------------- driver ----------------
   task automatic bus_access(input logic a_rs, input logic a_rwb, input logic [7:0] a_d,
                             output int low);
      logic oe_bad;
      @(negedge clk);
      rs = a_rs; rwb = a_rwb; din = a_d; phi2 = 1'b1; cs_n = 1'b0;
      low = 0; oe_bad = 1'b0;
      @(negedge clk);
      while (!rdy && low < 200) begin
         low++;
         if (doe) oe_bad = 1'b1;
         @(negedge clk);
      end
      chk("R8 oe low during stall", int'(oe_bad), 0);
      chk("R8 oe after completion", int'(doe), int'(a_rwb));
      @(negedge clk);
      cs_n = 1'b1; phi2 = 1'b0;
      @(negedge clk);
      chk("R8 oe released after deselect", int'(doe), 0);
   endtask

   task automatic rd(input logic a_rs, input logic [7:0] exp, input string tag);
      int low;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_access(a_rs, 1'b1, 8'h00, low);
   endtask

   task automatic wr(input logic a_rs, input logic [7:0] d);
      int low;
      bus_access(a_rs, 1'b0, d, low);
   endtask

   task automatic set_ptr(input logic [14:0] p);
      wr(1'b1, p[7:0]);
      wr(1'b1, {1'b0, p[14:8]});
   endtask

   initial begin
      int low, rc;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 rdy after reset", int'(rdy), 1);
      chk("R10 doe after reset", int'(doe), 0);
      chk("R10 req after reset", int'(be_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10 / R4 / R1: first data read uses pointer 0
      rd(1'b0, 8'h5A, "R10 pointer starts at 0");

      // R5: pointer load with bit7 clear; R4 writes with varied delays
      set_ptr(15'h0010);
      be_dly = 0;
      wr(1'b0, 8'hA1);
      be_dly = 4;
      exp_q = exp_q;
      bus_access(1'b0, 1'b0, 8'hA2, low);
      chk_rng("R3 stall follows backend delay 4", low, 5, 8);
      chk("R4 second write address", int'(last_addr), 'h11);
      chk("R4 second write data", int'(last_wdata), 'hA2);
      be_dly = 1;
      set_ptr(15'h0010);
      rd(1'b0, 8'hA1, "R4 readback first");
      rd(1'b0, 8'hA2, "R4 readback second");

      // R5: register write pair with bit7 set, pointer untouched
      wr(1'b1, 8'h3C);
      wr(1'b1, 8'h85);
      chk("R5 register 5 written", int'(bregs[5]), 'h3C);
      rd(1'b0, 8'h12 ^ 8'h5A, "R5 pointer kept by register write");

      // R6 / R1: register read of index 0, pair reset
      bregs[0] = 8'h9E;
      rd(1'b1, 8'h9E, "R6 register port read");
      wr(1'b1, 8'h77);
      rd(1'b1, 8'h9E, "R6 register read between pair bytes");
      set_ptr(15'h0020);
      rd(1'b0, 8'h20 ^ 8'h5A, "R6 pair restarted after register read");

      // R7: timeout
      be_nack = 1'b1;
      exp_q.push_back(8'hFF);
      tag_q.push_back("R7 timed-out read fill");
      bus_access(1'b0, 1'b1, 8'h00, low);
      chk_rng("R7 stall ends at timeout", low, 16, 18);
      be_nack = 1'b0;
      rd(1'b0, 8'h21 ^ 8'h5A, "R7 pointer unchanged by timeout");

      // R4: wrap at top of address space
      set_ptr(15'h7FFF);
      wr(1'b0, 8'h55);
      chk("R4 write at top address", int'(last_addr), 'h7FFF);
      rd(1'b0, 8'h5A, "R4 wrap read data");
      chk("R4 wrapped address", int'(last_addr), 0);

      // R2: unqualified selects start nothing
      rc = req_count;
      low = 0;
      @(negedge clk); phi2 = 1'b0; cs_n = 1'b0; rs = 1'b0; rwb = 1'b1;
      repeat (5) begin @(negedge clk); if (!rdy) low++; end
      cs_n = 1'b1; phi2 = 1'b1;
      repeat (5) begin @(negedge clk); if (!rdy) low++; end
      phi2 = 1'b0;
      @(negedge clk);
      chk("R2 no stall without strobe and select", low, 0);
      chk("R2 no request without strobe and select", req_count, rc);

      // R9: diagnostic byte
      diag_en = 1'b1;
      rc = req_count;
      bus_access(1'b1, 1'b0, 8'h40, low);
      chk("R9 diagnostic write stall one cycle", low, 1);
      rd(1'b0, 8'h40, "R9 diagnostic read data port");
      rd(1'b1, 8'h41, "R9 diagnostic read register port");
      chk("R9 no backend traffic", req_count, rc);
      diag_en = 1'b0;

      repeat (4) @(negedge clk);
      chk("R8 all expected reads seen", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule